// File: doc/BRIEF.md
# Diagnostic Serial Slave with Chained Fault Flag

This block is the 8-bit serial slave of a bridge-driver controller. A host selects it by pulling the chip select low, clocks eight bits in, and gets back the answer to the command it sent in the previous frame. Commands are told apart by their three top bits. They can read the diagnosis byte, read the revision byte, read the control register, write the control register, or clear the diagnosis logic through a one-cycle strobe.

Before the first rising serial clock edge of a frame, the serial output carries a fault flag instead of reply data. The flag is the OR of the local error status and the live serial input. When several devices are chained output-to-input, the host can read a summary fault from all of them without any clocks. The serial pins are oversampled by the system clock. Only the flag path is combinational from its inputs to the pin.

Top module: `spi_diag_slave`

## Requirements
- R1: `so_oe_o` is 0 outside a frame. It goes to 1 after the chip select falls and back to 0 after it rises. `so_o` is 0 whenever `so_oe_o` is 0.
- R2: From the chip-select fall until the first rising serial clock edge, `so_o` equals `err_i | si_i`, following both inputs combinationally.
- R3: The serial input is sampled on falling serial clock edges, MSB first. Bits [7:5] of the received byte are the opcode.
- R4: The reply is shifted out MSB first. Bit 7 appears after the first rising serial clock edge, and each later rising edge moves to the next lower bit. Beyond eight bits the output is 0.
- R5: The reply in frame n answers frame n-1. The first reply after reset is the revision byte, which is `{4'b0010, rev_i}`.
- R6: Opcode map. 000 returns diagnosis. 001 returns revision. 011 returns control. 100 returns diagnosis and clears. 111 writes control and returns control. 110 writes control and returns diagnosis. 010 and 101 return diagnosis.
- R7: `ctrl_o` resets to 0x00. A write opcode loads the whole received byte, including the opcode in bits [7:5], open-load disable in bit 4, serial control in bit 3, serial enable in bit 2, serial direction in bit 1 and serial PWM in bit 0.
- R8: A frame with any bit count other than eight writes nothing and raises no clear. Its following reply is the diagnosis byte.
- R9: `diag_clr_o` is a single-cycle pulse after the chip-select rise of a complete 100 frame.
- R10: Reply data is taken from `diag_i`, `rev_i` or the control register at the start of the replying frame, not when the command arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset (power-on or sleep) |
| csn_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data in |
| diag_i | input | 8 | Current diagnosis byte |
| rev_i | input | 4 | Revision nibble |
| err_i | input | 1 | High when the outputs are shut down or disabled |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data pad |
| ctrl_o | output | 8 | Control register |
| diag_clr_o | output | 1 | One-cycle diagnosis clear strobe |

## Verification
On every cycle, the assertions check several rules. The output enable must follow the frame boundaries. The bit counter must restart at each frame start. The flag phase may end only on a clock edge or a frame end. The control register may change, and the clear strobe may fire, only right after a frame end, and the strobe is never longer than one cycle. The bench scenarios show the rest: the value of each reply against the previous command, the revision reply after reset, live sampling of the diagnosis byte, the flag's OR with the serial input, and short or long frames being ignored.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

  typedef enum logic [1:0] {
    SRC_DIAG = 2'd0,
    SRC_REV  = 2'd1,
    SRC_CTRL = 2'd2
  } reply_src_e;

  typedef struct packed {
    logic       wr_ctrl;
    logic       clr_diag;
    reply_src_e src;
  } cmd_action_t;

  function automatic cmd_action_t decode_cmd(input logic [2:0] op);
    cmd_action_t a;
    a.wr_ctrl  = 1'b0;
    a.clr_diag = 1'b0;
    a.src      = SRC_DIAG;
    case (op)
      3'b001: a.src = SRC_REV;
      3'b011: a.src = SRC_CTRL;
      3'b100: a.clr_diag = 1'b1;
      3'b111: begin a.wr_ctrl = 1'b1; a.src = SRC_CTRL; end
      3'b110: a.wr_ctrl = 1'b1;
      default: a.src = SRC_DIAG;
    endcase
    return a;
  endfunction

  function automatic logic [7:0] rev_byte(input logic [3:0] nib);
    return {4'b0010, nib};
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
      prev_q  <= RESET_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample,
  input  logic              din,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (start) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (sample) begin
      sh_q <= {sh_q[DATA_W-2:0], din};
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_o = sh_q;
  assign full_o = (cnt_q == CNT_W'(DATA_W));

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_evt,
  input  logic              stop,
  input  logic              err_i,
  input  logic              si_raw,
  output logic              so,
  output logic              so_oe,
  output logic              flag_phase
);
  logic [DATA_W-1:0] sh_q;
  logic              act_q;
  logic              flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      act_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (load) begin
      sh_q   <= load_data;
      act_q  <= 1'b1;
      flag_q <= 1'b1;
    end else if (stop) begin
      act_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (shift_evt) begin
      if (flag_q) flag_q <= 1'b0;
      else        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign so_oe      = act_q;
  assign flag_phase = flag_q;
  assign so         = act_q & (flag_q ? (err_i | si_raw) : sh_q[DATA_W-1]);

  AST_OE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (so_oe && flag_phase)); // R1
  AST_OE_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> !so_oe); // R1
  AST_FLAG_ENDS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_phase) |-> ($past(shift_evt) || $past(stop))); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !so_oe |-> !so); // R1
endmodule

// File: rtl/spi_diag_slave.sv
module spi_diag_slave
  import spi_diag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic [DATA_W-1:0] diag_i,
  input  logic [REV_W-1:0]  rev_i,
  input  logic              err_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              diag_clr_o
);
  localparam int CNT_W = $clog2(DATA_W) + 2;
  localparam int NPINS = 3;
  localparam logic [NPINS-1:0] PIN_RST = 3'b001;

  logic [NPINS-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  assign pin_raw = {si_i, sck_i, csn_i};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    spi_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(PIN_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_raw[g]),
      .level(pin_lvl[g]), .rise(pin_rise[g]), .fall(pin_fall[g]));
  end

  logic frame_start, frame_end, bit_in, bit_out, active, flag_phase;
  assign frame_start = pin_fall[0];
  assign frame_end   = pin_rise[0] & active;
  assign bit_in      = pin_fall[1] & active & ~pin_lvl[0];
  assign bit_out     = pin_rise[1] & active & ~pin_lvl[0];

  logic [DATA_W-1:0] rx_byte;
  logic              rx_full;

  spi_rx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .sample(bit_in),
    .din(pin_lvl[2]), .data_o(rx_byte), .full_o(rx_full));

  reply_src_e        src_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              clr_q;
  cmd_action_t       act;
  logic [DATA_W-1:0] reply_data;

  assign act = decode_cmd(rx_byte[DATA_W-1 -: 3]);

  always_comb begin
    case (src_q)
      SRC_REV:  reply_data = DATA_W'(rev_byte(rev_i));
      SRC_CTRL: reply_data = ctrl_q;
      default:  reply_data = diag_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_REV;
      ctrl_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (frame_end) begin
        if (rx_full) begin
          src_q <= act.src;
          if (act.wr_ctrl) ctrl_q <= rx_byte;
          clr_q <= act.clr_diag;
        end else begin
          src_q <= SRC_DIAG;
        end
      end
    end
  end

  spi_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .load_data(reply_data),
    .shift_evt(bit_out), .stop(frame_end), .err_i(err_i), .si_raw(si_i),
    .so(so_o), .so_oe(active), .flag_phase(flag_phase));

  assign so_oe_o    = active;
  assign ctrl_o     = ctrl_q;
  assign diag_clr_o = clr_q;

  AST_CTRL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> $past(frame_end)); // R7
  AST_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr_o |-> $past(frame_end)); // R9
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr_o |=> !diag_clr_o); // R9
  AST_FLAG_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    flag_phase |-> so_oe_o); // R2
endmodule

// File: tb/spi_diag_slave_tb.sv
module spi_diag_slave_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csn = 1'b1, sck = 1'b0, si = 1'b0, err = 1'b0;
  logic [7:0] diag = 8'hDF;
  logic [3:0] rev = 4'h5;
  logic       so, so_oe, clr;
  logic [7:0] ctrl;

  int n_chk = 0, n_fail = 0, clr_cnt = 0;
  int m_src = 1;            // 0 diag, 1 rev, 2 ctrl
  logic [7:0] m_ctrl = 8'h00;

  always #10 clk = ~clk;

  spi_diag_slave u_dut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sck_i(sck), .si_i(si),
    .diag_i(diag), .rev_i(rev), .err_i(err), .so_o(so), .so_oe_o(so_oe),
    .ctrl_o(ctrl), .diag_clr_o(clr));

  always @(posedge clk) if (clr) clr_cnt++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_reply();
    if (m_src == 1) return {4'b0010, rev};
    if (m_src == 2) return m_ctrl;
    return diag;
  endfunction

  task automatic frame(input logic [7:0] cmd, input int nbits);
    logic [7:0] exp_r, got;
    int clr0, exp_clr;
    exp_r = exp_reply();
    got = 8'h00;
    clr0 = clr_cnt;
    @(negedge clk);
    si = 1'b0; csn = 1'b0;
    waitc(HALF);
    check("R1 oe in frame", {7'b0, so_oe}, 8'h01);
    check("R2 flag si=0", {7'b0, so}, {7'b0, err});
    si = 1'b1; waitc(2);
    check("R2 flag si=1", {7'b0, so}, 8'h01);
    for (int i = 0; i < nbits; i++) begin
      si = (i < 8) ? cmd[7-i] : 1'b0;
      sck = 1'b1; waitc(HALF);
      if (i < 8) got[7-i] = so;
      else check("R4 beyond eight", {7'b0, so}, 8'h00);
      sck = 1'b0; waitc(HALF);
    end
    if (nbits > 0) begin
      int k = (nbits < 8) ? nbits : 8;
      logic [7:0] mask = 8'hFF << (8 - k);
      check("R4 R5 R10 reply", got & mask, exp_r & mask);
    end
    csn = 1'b1; waitc(2 * HALF);
    check("R1 oe idle", {6'b0, so_oe, so}, 8'h00);
    exp_clr = 0;
    if (nbits == 8) begin
      case (cmd[7:5])
        3'b001: m_src = 1;
        3'b011: m_src = 2;
        3'b111: begin m_ctrl = cmd; m_src = 2; end
        3'b110: begin m_ctrl = cmd; m_src = 0; end
        3'b100: begin m_src = 0; exp_clr = 1; end
        default: m_src = 0;
      endcase
    end else m_src = 0;        // R8
    check("R7 R8 ctrl", ctrl, m_ctrl);
    check("R9 R8 clr count", 8'(clr_cnt - clr0), 8'(exp_clr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    check("R1 reset oe", {7'b0, so_oe}, 8'h00);
    check("R7 reset ctrl", ctrl, 8'h00);
    check("R9 reset clr", {7'b0, clr}, 8'h00);
    frame(8'h00, 8);                         // R5 first reply revision
    for (int op = 0; op < 8; op++) begin
      for (int d = 0; d < 4; d++) begin
        logic [7:0] c = {op[2:0], 5'(d * 9 + op)};
        err  = d[0];
        diag = 8'(8'hC3 ^ (op * 16 + d));    // R10 live diagnosis
        rev  = 4'(op + d);
        frame(c, 8);                         // R3 R6
        frame(8'h60, 8);                     // read control
      end
    end
    frame(8'hFF, 5);                         // R8 short frame
    frame(8'hE3, 10);                        // R8 long frame
    frame(8'h20, 0);                         // R8 no clocks
    frame(8'h20, 8);
    frame(8'h00, 8);                         // R5 revision reply
    frame(8'h9F, 7);                         // R8 no clear
    frame(8'h00, 8);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule